// File: doc/BRIEF.md
# Cascaded-Prescaler UART Baud Generator

This block produces the two timing pulses that a UART transmitter and receiver run on: a sample tick, one per oversampling period, and a bit tick, one per bit time. Its rate source is one of five clock-enable strobes in the system clock domain: a crystal reference strobe or one of four alternate strobes. The selected strobe passes through two 3-bit prescalers, then a 10-bit divider, then a programmable oversampling counter. The bit rate is therefore the source strobe rate divided by the product of the oversampling factor, both prescalers and the divider.

Configuration arrives as two 32-bit words. The first is a baud word carrying the divider, the prescalers and the source choice. The second is an oversampling word carrying the factor. A written word is held pending and takes effect only while the transmitter reports it is empty. All counters restart at that point, so the first period under the new setting is a whole period.

Top module: `baud_cascade`

## Requirements
- R1: Baud word decode: divider in bits [9:0], alternate-source index in bits [11:10], second prescaler in bits [14:12], first prescaler in bits [17:15], and source select in bit 19 (1 = alternate source given by the index, 0 = crystal strobe). Divider values up to 1023 and prescaler values up to 7 are honoured.
- R2: A divider or prescaler field of 0 behaves as 1, so ticks keep coming.
- R3: The oversampling factor is bits [5:0] of the oversampling word. A value of 0 means 16, and values 1 to 63 are used as written. Bits above [5:0], including the fields at offsets 8, 16 and 24, do not change the ticks.
- R4: One sample tick occurs for every (first prescaler × second prescaler × divider) strobes of the selected source, counted from reset or from the last configuration change.
- R5: The bit tick coincides with every factor-th sample tick, counted from the same starting point.
- R6: Strobes from sources that are not selected have no effect on either tick.
- R7: A write to either word is held pending. The active setting changes only in a cycle where a write is pending, tx_empty is high and no new write is presented; otherwise it is unchanged.
- R8: When a pending setting is applied, no tick is issued in that cycle, the strobe in that cycle is not counted, and every counter restarts, so the first tick under the new setting follows a full period.
- R9: Synchronous active-high reset sets divider 1, both prescalers 1, the crystal source, the 16x factor and no pending write; both ticks are low during and right after reset.
- R10: Each tick is a one-cycle pulse that goes high in the cycle after the clock edge at which its final counted strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_baud | input | 1 | Write strobe for the baud word |
| wr_os | input | 1 | Write strobe for the oversampling word |
| wdata | input | 32 | Write data for either word |
| xtal_en | input | 1 | Crystal reference clock-enable strobe |
| alt_en | input | 4 | Alternate source clock-enable strobes |
| tx_empty | input | 1 | Transmitter idle status; gates the application of a pending setting |
| sample_tick | output | 1 | One-cycle pulse per oversampling period |
| bit_tick | output | 1 | One-cycle pulse per bit time |

## Verification
Directed runs use strobes on every cycle, so each tick period can be read directly in cycles. They cover the reset default, an alternate source whose strobe is gapped while the other sources run continuously, all-zero fields, the full 1023 divider, both prescalers at 6, and factors of 63 and of 0 with non-zero upper fields. These runs separate errors in field position, zero handling, stage order and factor decode. Randomised runs then vary the strobe density, the tx_empty pattern and the time between writes. This exposes errors in the pending/apply handshake and in counter restart that a steady strobe pattern would hide. A reference model in the bench counts selected strobes since the last change and predicts every tick.

// File: rtl/baud_cascade.sv
`timescale 1ns/1ps
module baud_cascade #(
  parameter int DIV_W  = 10,
  parameter int PRE_W  = 3,
  parameter int OS_W   = 6,
  parameter int NALT   = 4,
  parameter int DEF_OS = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_baud,
  input  logic              wr_os,
  input  logic [WORD_W-1:0] wdata,
  input  logic              xtal_en,
  input  logic [NALT-1:0]   alt_en,
  input  logic              tx_empty,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int SEL_W   = $clog2(NALT);
  localparam int SEL_LSB = DIV_W;
  localparam int D2_LSB  = SEL_LSB + SEL_W;
  localparam int D1_LSB  = D2_LSB + PRE_W;
  localparam int ALT_BIT = 19;
  localparam int CFG_W   = D1_LSB + PRE_W + 1;
  localparam int NSTG    = 3;
  localparam logic [CFG_W-1:0] RST_CFG =
    CFG_W'(1) | (CFG_W'(1) << D2_LSB) | (CFG_W'(1) << D1_LSB);

  function automatic logic [DIV_W-1:0] stage_len(input logic [CFG_W-1:0] c, input int s);
    logic [DIV_W-1:0] v;
    case (s)
      0:       v = DIV_W'(c[D1_LSB +: PRE_W]);
      1:       v = DIV_W'(c[D2_LSB +: PRE_W]);
      default: v = c[DIV_W-1:0];
    endcase
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  function automatic logic [OS_W-1:0] os_len(input logic [OS_W-1:0] f);
    return (f == '0) ? OS_W'(DEF_OS) : f;
  endfunction

  logic [CFG_W-1:0] pend_cfg, act_cfg;
  logic [OS_W-1:0]  pend_os, act_os, os_cnt;
  logic             pending;
  logic [NSTG-1:0]  stg_in, stg_fire;
  logic             unused_bits;

  wire [CFG_W-1:0] wr_cfg = {wdata[ALT_BIT], wdata[D1_LSB+PRE_W-1:0]};
  wire             cfg_wr = wr_baud | wr_os;
  wire             apply  = pending & tx_empty & ~cfg_wr;
  wire [SEL_W-1:0] src_idx = act_cfg[SEL_LSB +: SEL_W];
  wire             src_en = act_cfg[CFG_W-1] ? alt_en[src_idx] : xtal_en;

  assign unused_bits = ^{wdata[WORD_W-1:ALT_BIT+1], wdata[ALT_BIT-1:D1_LSB+PRE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cfg <= RST_CFG;
      act_cfg  <= RST_CFG;
      pend_os  <= '0;
      act_os   <= '0;
      pending  <= 1'b0;
    end else begin
      if (wr_baud) pend_cfg <= wr_cfg;
      if (wr_os)   pend_os  <= wdata[OS_W-1:0];
      if (cfg_wr) begin
        pending <= 1'b1;
      end else if (apply) begin
        act_cfg <= pend_cfg;
        act_os  <= pend_os;
        pending <= 1'b0;
      end
    end
  end

  assign stg_in[0] = src_en;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic [DIV_W-1:0] cnt;
    assign stg_fire[s] = stg_in[s] && (cnt == '0);
    if (s < NSTG-1) begin : g_link
      assign stg_in[s+1] = stg_fire[s];
    end
    always_ff @(posedge clk) begin
      if (rst)              cnt <= stage_len(RST_CFG, s) - 1'b1;
      else if (apply)       cnt <= stage_len(pend_cfg, s) - 1'b1;
      else if (stg_fire[s]) cnt <= stage_len(act_cfg, s) - 1'b1;
      else if (stg_in[s])   cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     os_cnt <= OS_W'(DEF_OS - 1);
    else if (apply)              os_cnt <= os_len(pend_os) - 1'b1;
    else if (stg_fire[NSTG-1])   os_cnt <= (os_cnt == '0) ? os_len(act_os) - 1'b1 : os_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= stg_fire[NSTG-1] & ~apply;
      bit_tick    <= stg_fire[NSTG-1] & ~apply & (os_cnt == '0);
    end
  end
endmodule

module baud_cascade_chk #(
  parameter int CFG_W = 19,
  parameter int OS_W  = 6,
  parameter logic [CFG_W-1:0] RST_CFG = 19'h09001
) (
  input logic             clk,
  input logic             rst,
  input logic             pending,
  input logic             tx_empty,
  input logic [CFG_W-1:0] act_cfg,
  input logic [OS_W-1:0]  act_os,
  input logic             src_en,
  input logic             sample_tick,
  input logic             bit_tick
);
  // R5
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);
  // R7
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !tx_empty) |=> ($stable(act_cfg) && $stable(act_os)));
  // R7
  no_spurious_apply_chk: assert property (@(posedge clk) disable iff (rst)
    !pending |=> ($stable(act_cfg) && $stable(act_os)));
  // R9
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (act_cfg == RST_CFG && act_os == '0 && !pending && !sample_tick));
  // R10
  tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    sample_tick |-> $past(src_en));
  // R8
  quiet_on_apply_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> !sample_tick);
endmodule

bind baud_cascade baud_cascade_chk u_chk (
  .clk(clk), .rst(rst), .pending(pending), .tx_empty(tx_empty),
  .act_cfg(act_cfg), .act_os(act_os), .src_en(src_en),
  .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/baud_cascade_tb.sv
`timescale 1ns/1ps
module baud_cascade_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_baud = 0, wr_os = 0, xtal_en = 0, tx_empty = 0;
  logic [31:0] wdata = '0;
  logic [3:0] alt_en = '0;
  logic sample_tick, bit_tick;

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "init";

  logic [31:0] m_pbaud, m_pos, m_abaud, m_aos;
  bit m_pend, es, eb;
  longint m_cnt;

  baud_cascade u_dut (.clk(clk), .rst(rst), .wr_baud(wr_baud), .wr_os(wr_os),
    .wdata(wdata), .xtal_en(xtal_en), .alt_en(alt_en), .tx_empty(tx_empty),
    .sample_tick(sample_tick), .bit_tick(bit_tick));

  always #10 clk = ~clk;

  function automatic longint nz(input longint v);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic longint kval(input logic [31:0] w);
    return nz(w[9:0]) * nz(w[17:15]) * nz(w[14:12]);
  endfunction
  function automatic longint oval(input logic [31:0] w);
    return (w[5:0] == 0) ? 16 : longint'(w[5:0]);
  endfunction

  task automatic check_out();
    total += 2;
    if (sample_tick !== es) begin
      bad++;
      $display("FAIL %s R4 sample_tick got %0b exp %0b", phase, sample_tick, es);
    end
    if (bit_tick !== eb) begin
      bad++;
      $display("FAIL %s R5 bit_tick got %0b exp %0b", phase, bit_tick, eb);
    end
  endtask

  task automatic step(input logic r, input logic wb, input logic wo, input logic [31:0] d,
                      input logic tx, input logic xe, input logic [3:0] ae);
    bit strobe;
    check_out();
    rst = r; wr_baud = wb; wr_os = wo; wdata = d; tx_empty = tx; xtal_en = xe; alt_en = ae;
    if (r) begin
      m_pbaud = 32'h0000_9001; m_abaud = 32'h0000_9001;
      m_pos = 0; m_aos = 0; m_pend = 0; m_cnt = 0; es = 0; eb = 0;
    end else if (!(wb || wo) && m_pend && tx) begin
      m_abaud = m_pbaud; m_aos = m_pos; m_pend = 0; m_cnt = 0; es = 0; eb = 0;
    end else begin
      if (wb) m_pbaud = d;
      if (wo) m_pos = d;
      if (wb || wo) m_pend = 1;
      strobe = m_abaud[19] ? ae[m_abaud[11:10]] : xe;
      if (strobe) begin
        m_cnt++;
        es = (m_cnt % kval(m_abaud)) == 0;
        eb = (m_cnt % (kval(m_abaud) * oval(m_aos))) == 0;
      end else begin
        es = 0; eb = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input int tx_pct, input int str_pct);
    for (int i = 0; i < n; i++)
      step(0, 0, 0, '0, $urandom_range(0, 99) < tx_pct, $urandom_range(0, 99) < str_pct,
           {$urandom_range(0, 99) < str_pct, $urandom_range(0, 99) < str_pct,
            $urandom_range(0, 99) < str_pct, $urandom_range(0, 99) < str_pct});
  endtask

  task automatic full(input int n, input logic [3:0] ae_mask, input bit gap);
    for (int i = 0; i < n; i++)
      step(0, 0, 0, '0, 1, 1, gap ? (ae_mask & {4{i[0]}}) | ~ae_mask : 4'hf);
  endtask

  task automatic cfg(input logic [31:0] bw, input logic [31:0] ow);
    step(0, 1, 0, bw, 0, 1, 4'hf);
    step(0, 0, 1, ow, 0, 1, 4'hf);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R9: reset values, ticks low during reset
    phase = "R9 reset";
    for (int i = 0; i < 4; i++) step(1, 0, 0, '0, 1, 1, 4'hf);
    // R9 R4 R5 R10: defaults give a sample tick per strobe and a bit tick every 16
    phase = "R9 default";
    full(50, 4'h0, 0);
    // R6 R1: alternate source 2 gapped, others always active; divider 3
    phase = "R6 alt source";
    cfg(32'h0008_9803, 32'h0000_0004);
    full(200, 4'b0100, 1);
    // R7: setting held while transmitter busy
    phase = "R7 pending hold";
    cfg(32'h0000_9002, 32'h0000_0003);
    for (int i = 0; i < 150; i++) step(0, 0, 0, '0, 0, 1, 4'hf);
    full(60, 4'h0, 0);
    // R2: all fields zero act as one
    phase = "R2 zero fields";
    cfg(32'h0000_0000, 32'h0000_0002);
    full(60, 4'h0, 0);
    // R1: largest divider
    phase = "R1 max divider";
    cfg(32'h0000_93ff, 32'h0000_0002);
    full(4200, 4'h0, 0);
    // R1: both prescalers at 6
    phase = "R1 prescalers";
    cfg(32'h0003_6002, 32'h0000_0001);
    full(400, 4'h0, 0);
    // R3: largest factor, then factor 0 with upper fields set
    phase = "R3 max factor";
    cfg(32'h0000_9001, 32'h0000_003f);
    full(200, 4'h0, 0);
    phase = "R3 upper fields";
    cfg(32'h0000_9001, 32'h3f3f_3f00);
    full(100, 4'h0, 0);
    // R8: write in the same cycle tx_empty is high defers apply; restart gives full period
    phase = "R8 restart";
    step(0, 1, 0, 32'h0000_9004, 1, 1, 4'hf);
    full(30, 4'h0, 0);
    // random mixture
    for (int it = 0; it < 30; it++) begin
      logic [31:0] bw, ow;
      phase = $sformatf("R7 R8 random %0d", it);
      bw = {12'($urandom), 1'($urandom_range(0, 1)), 1'($urandom),
            3'($urandom_range(0, 3)), 3'($urandom_range(0, 3)), 2'($urandom),
            10'($urandom_range(0, 6))};
      ow = {2'b0, 6'($urandom), 2'b0, 6'($urandom), 2'b0, 6'($urandom),
            2'b0, 6'($urandom_range(0, 6))};
      step(0, 1, 0, bw, $urandom_range(0, 1), 1, 4'hf);
      run($urandom_range(0, 20), 30, 60);
      step(0, 0, 1, ow, $urandom_range(0, 1), 1, 4'hf);
      run(1200, 85, 70);
    end
    check_out();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R4 got hung exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule